// File: doc/BRIEF.md
# MDIO Management Slave with Indirect Extended-Register Window

This block is the management end of a two-wire serial control bus. It samples the data line on every rising edge of the management clock and parses read and write frames. It responds only to frames that carry its own 5-bit station address. That address is taken from strap inputs while reset is held. When it answers a read, it drives the line through a data bit and a separate output-enable, so that a pad outside the block can form the bidirectional pin.

Behind the frame parser there are three kinds of register:
- a handful of plain read/write registers;
- a control register at 0x0D;
- a window register at 0x0E.

The window gives indirect access to a larger extended register array. The control register holds a device number and a two-bit function code. The function code decides what an access to 0x0E does:
- it loads or reads a stored pointer;
- or it reaches the extended register that the pointer selects, and may step the pointer afterwards.

A host programs an extended register in four writes. It writes 0x001F to 0x0D, then the target index to 0x0E, then 0x401F to 0x0D, and finally the data to 0x0E.

The parser is a single state machine with seven states:
- **ST_HUNT** counts consecutive ones, saturating at the preamble length.
- **ST_START** expects the second start bit.
- **ST_OPCODE**, **ST_PHYAD** and **ST_REGAD** collect the command fields.
- **ST_TURN** covers the two turnaround cycles.
- **ST_DATA** covers the 16 data bits.

Transitions:
- HUNT→START on a zero that follows a full preamble.
- START→OPCODE on a one; START→HUNT on a zero.
- OPCODE→PHYAD on a valid opcode; OPCODE→HUNT on any other opcode.
- PHYAD→REGAD and REGAD→TURN after five bits each.
- TURN→DATA after two bits.
- DATA→HUNT after sixteen bits.

In the first cycle after reset, the machine is forced to HUNT with a cleared count.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The station address is captured from `phy_addr_strap` only while `rst_n` is low. A frame whose address field differs from it changes no register, and `mdio_oe` stays 0 for the whole frame.
- R2: A frame is at least 32 ones, then start bits 0,1, then opcode 1,0 (read) or 0,1 (write), then a 5-bit station address, a 5-bit register address, two turnaround bits and 16 data bits, all MSB first. A frame with opcode 0,0 or 1,1 is dropped and writes nothing.
- R3: A frame preceded by only 31 consecutive ones is ignored.
- R4: The bit sampled on the first rising clock edge after reset deasserts is discarded. A frame whose first preamble one lies in that cycle therefore has one preamble bit too few.
- R5: On a matching read, `mdio_oe` is 0 during the first turnaround cycle. During the second turnaround cycle `mdio_oe`=1 and `mdio_out`=0. The 16 data bits follow MSB first, one per cycle, each changing after a rising edge. `mdio_oe` returns to 0 in the cycle after the last data bit.
- R6: Registers 0 to NUM_DIRECT-1 (8 by default) are 16-bit read/write and reset to 0. Any other address except 0x0D and 0x0E reads 0 and ignores writes.
- R7: Register 0x0D holds the function code in bits 15:14 and the device number in bits 4:0. Its other bits read 0, and it resets to 0.
- R8: With function 00, register 0x0E reads and writes the stored extended pointer.
- R9: With function 01 and device number 31, register 0x0E reads and writes the extended register at the pointer. The pointer is not changed.
- R10: With function 10 and device number 31, the pointer increments by one after every data read and every data write through 0x0E.
- R11: With function 11 and device number 31, the pointer increments after data writes only. Data reads leave it unchanged.
- R12: With a nonzero function and a device number other than 31, accesses to 0x0E read 0, write nothing and leave the pointer unchanged. A pointer at or beyond EXT_DEPTH (32) reads 0 and discards writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_strap | input | 5 | Station address, captured while reset is low |
| mdio_in | input | 1 | Sampled value of the management data line |
| mdio_out | output | 1 | Data value to place on the line when enabled |
| mdio_oe | output | 1 | Drive enable for the management data line |

## Verification
Two functions share a single clock edge: the data write through 0x0E into the extended array, and the post-increment of the pointer that selects the written element. A read likewise captures a value and schedules an increment at the end of the same frame. The bench triggers this by writing two back-to-back values in the auto-increment modes. It then returns to function 01, repositions the pointer and reads both elements. Each value must appear at its own index, and the pointer must have advanced by exactly two. Function 11 is judged the same way, with the extra condition that two consecutive reads return the same element.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int WORD_W = 16;
    localparam int FIELD_W = 5;

    localparam logic [FIELD_W-1:0] REG_CTRL = 5'h0D;
    localparam logic [FIELD_W-1:0] REG_WIN  = 5'h0E;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    typedef enum logic [1:0] {
        FN_ADDR   = 2'b00,
        FN_DATA   = 2'b01,
        FN_INC_RW = 2'b10,
        FN_INC_WR = 2'b11
    } win_fn_e;

endpackage

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] strap,
    input  logic               mdio_in,
    input  logic [WORD_W-1:0]  rd_data,
    output logic [FIELD_W-1:0] acc_reg,
    output logic               wr_stb,
    output logic [WORD_W-1:0]  wr_data,
    output logic               rd_done,
    output logic               mdio_out,
    output logic               mdio_oe
);

    localparam int CNTW = $clog2(PREAMBLE_LEN + 1);
    localparam logic [CNTW-1:0] PRE_FULL = CNTW'(PREAMBLE_LEN);
    localparam logic [CNTW-1:0] LAST_FLD = CNTW'(FIELD_W - 1);
    localparam logic [CNTW-1:0] LAST_DAT = CNTW'(WORD_W - 1);

    mdio_state_e        state_q, nxt_state;
    logic [CNTW-1:0]    cnt_q, nxt_cnt;
    logic [FIELD_W-1:0] my_addr_q;
    logic               quiet_q;
    logic               is_rd_q, nxt_rd;
    logic               hit_q, nxt_hit;
    logic [FIELD_W-1:0] reg_q, nxt_reg;
    logic [WORD_W-2:0]  sh_q;
    logic [WORD_W-1:0]  tx_q;
    logic [FIELD_W-1:0] field_w;

    assign field_w = {sh_q[FIELD_W-2:0], mdio_in};

    // next-state logic
    always_comb begin
        nxt_state = state_q;
        nxt_cnt   = CNTW'(cnt_q + 1'b1);
        nxt_rd    = is_rd_q;
        nxt_hit   = hit_q;
        nxt_reg   = reg_q;
        if (quiet_q) begin
            nxt_state = ST_HUNT;
            nxt_cnt   = '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (mdio_in) begin
                        nxt_cnt = (cnt_q == PRE_FULL) ? cnt_q : CNTW'(cnt_q + 1'b1);
                    end else begin
                        nxt_cnt = '0;
                        if (cnt_q == PRE_FULL) nxt_state = ST_START;
                    end
                end
                ST_START: begin
                    nxt_cnt   = '0;
                    nxt_state = mdio_in ? ST_OPCODE : ST_HUNT;
                end
                ST_OPCODE: begin
                    if (cnt_q == CNTW'(1)) begin
                        nxt_cnt = '0;
                        if ({sh_q[0], mdio_in} == 2'b10) begin
                            nxt_rd    = 1'b1;
                            nxt_state = ST_PHYAD;
                        end else if ({sh_q[0], mdio_in} == 2'b01) begin
                            nxt_rd    = 1'b0;
                            nxt_state = ST_PHYAD;
                        end else begin
                            nxt_state = ST_HUNT;
                        end
                    end
                end
                ST_PHYAD: begin
                    if (cnt_q == LAST_FLD) begin
                        nxt_cnt   = '0;
                        nxt_hit   = (field_w == my_addr_q);
                        nxt_state = ST_REGAD;
                    end
                end
                ST_REGAD: begin
                    if (cnt_q == LAST_FLD) begin
                        nxt_cnt   = '0;
                        nxt_reg   = field_w;
                        nxt_state = ST_TURN;
                    end
                end
                ST_TURN: begin
                    if (cnt_q == CNTW'(1)) begin
                        nxt_cnt   = '0;
                        nxt_state = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == LAST_DAT) begin
                        nxt_cnt   = '0;
                        nxt_state = ST_HUNT;
                    end
                end
                default: begin
                    nxt_cnt   = '0;
                    nxt_state = ST_HUNT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_HUNT;
            cnt_q     <= '0;
            my_addr_q <= strap;
            quiet_q   <= 1'b1;
            is_rd_q   <= 1'b0;
            hit_q     <= 1'b0;
            reg_q     <= '0;
            sh_q      <= '0;
        end else begin
            quiet_q <= 1'b0;
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
            is_rd_q <= nxt_rd;
            hit_q   <= nxt_hit;
            reg_q   <= nxt_reg;
            sh_q    <= {sh_q[WORD_W-3:0], mdio_in};
        end
    end

    assign acc_reg = reg_q;
    assign wr_data = {sh_q, mdio_in};
    assign wr_stb  = !quiet_q && (state_q == ST_DATA) && (cnt_q == LAST_DAT) && !is_rd_q && hit_q;
    assign rd_done = !quiet_q && (state_q == ST_DATA) && (cnt_q == LAST_DAT) && is_rd_q && hit_q;

    // line driver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            tx_q     <= '0;
        end else if ((state_q == ST_TURN) && (cnt_q == '0) && is_rd_q && hit_q) begin
            mdio_oe  <= 1'b1;
            mdio_out <= 1'b0;
            tx_q     <= rd_data;
        end else if (((state_q == ST_TURN) || (state_q == ST_DATA)) && mdio_oe) begin
            if ((state_q == ST_DATA) && (cnt_q == LAST_DAT)) begin
                mdio_oe  <= 1'b0;
                mdio_out <= 1'b0;
            end else begin
                mdio_out <= tx_q[WORD_W-1];
                tx_q     <= {tx_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    AST_DRIVE_OWN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (is_rd_q && hit_q)); // R1
    AST_TA1_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TURN) && (cnt_q == '0)) |-> !mdio_oe); // R5
    AST_TA2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TURN) && (cnt_q == '0) && is_rd_q && hit_q) |=> (mdio_oe && !mdio_out)); // R5
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> (state_q == ST_HUNT)); // R5
    AST_QUIET_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q |=> ((state_q == ST_HUNT) && (cnt_q == '0))); // R4

endmodule

// File: rtl/mdio_reg_bank.sv
`timescale 1ns/1ps
module mdio_reg_bank
    import mdio_pkg::*;
#(
    parameter int NUM_DIRECT = 8,
    parameter int EXT_DEPTH  = 32,
    parameter int EXT_DEVAD  = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] acc_reg,
    input  logic               wr_stb,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_done,
    output logic [WORD_W-1:0]  rd_data
);

    localparam int EXT_AW = (EXT_DEPTH > 1) ? $clog2(EXT_DEPTH) : 1;
    localparam logic [FIELD_W-1:0] DEV_EXT = FIELD_W'(EXT_DEVAD);

    logic [WORD_W-1:0]  dir_q [NUM_DIRECT];
    logic [WORD_W-1:0]  ext_q [EXT_DEPTH];
    win_fn_e            fn_q;
    logic [FIELD_W-1:0] devad_q;
    logic [WORD_W-1:0]  ptr_q;

    logic ext_sel, in_range, ext_ok, is_win, data_mode, inc_now;

    assign ext_sel   = (devad_q == DEV_EXT);
    assign in_range  = (ptr_q < WORD_W'(EXT_DEPTH));
    assign ext_ok    = ext_sel && in_range;
    assign is_win    = (acc_reg == REG_WIN);
    assign data_mode = (fn_q != FN_ADDR);
    assign inc_now   = is_win && ext_sel &&
                       ((wr_stb && ((fn_q == FN_INC_RW) || (fn_q == FN_INC_WR))) ||
                        (rd_done && (fn_q == FN_INC_RW)));

    // read multiplexer
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_DIRECT; i++) begin
            if (acc_reg == FIELD_W'(i)) rd_data = dir_q[i];
        end
        if (acc_reg == REG_CTRL) begin
            rd_data = {fn_q, {(WORD_W-2-FIELD_W){1'b0}}, devad_q};
        end else if (is_win) begin
            if (!data_mode)  rd_data = ptr_q;
            else if (ext_ok) rd_data = ext_q[ptr_q[EXT_AW-1:0]];
        end
    end

    // plain registers
    for (genvar g = 0; g < NUM_DIRECT; g++) begin : g_direct
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 dir_q[g] <= '0;
            else if (wr_stb && (acc_reg == FIELD_W'(g))) dir_q[g] <= wr_data;
        end
    end

    // indirect control, pointer and extended array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q    <= FN_ADDR;
            devad_q <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < EXT_DEPTH; i++) ext_q[i] <= '0;
        end else begin
            if (wr_stb && (acc_reg == REG_CTRL)) begin
                fn_q    <= win_fn_e'(wr_data[WORD_W-1:WORD_W-2]);
                devad_q <= wr_data[FIELD_W-1:0];
            end
            if (wr_stb && is_win) begin
                if (!data_mode)  ptr_q <= wr_data;
                else if (ext_ok) ext_q[ptr_q[EXT_AW-1:0]] <= wr_data;
            end
            if (inc_now) ptr_q <= WORD_W'(ptr_q + 1'b1);
        end
    end

    AST_PTR_STEP_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_win && (fn_q == FN_INC_RW) && ext_sel) |=> (ptr_q == WORD_W'($past(ptr_q) + 1'b1))); // R10
    AST_PTR_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && (fn_q == FN_INC_WR)) |=> $stable(ptr_q)); // R11
    AST_PTR_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (fn_q == FN_DATA)) |=> $stable(ptr_q)); // R9
    AST_PTR_HOLD_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && data_mode) |=> $stable(ptr_q)); // R12

endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32,
    parameter int NUM_DIRECT   = 8,
    parameter int EXT_DEPTH    = 32,
    parameter int EXT_DEVAD    = 31
) (
    input  logic       mdc,
    input  logic       rst_n,
    input  logic [4:0] phy_addr_strap,
    input  logic       mdio_in,
    output logic       mdio_out,
    output logic       mdio_oe
);

    logic [FIELD_W-1:0] acc_reg;
    logic               wr_stb, rd_done;
    logic [WORD_W-1:0]  wr_data, rd_data;

    mdio_frame_fsm #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_fsm (
        .clk      (mdc),
        .rst_n    (rst_n),
        .strap    (phy_addr_strap),
        .mdio_in  (mdio_in),
        .rd_data  (rd_data),
        .acc_reg  (acc_reg),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_done  (rd_done),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_bank #(
        .NUM_DIRECT (NUM_DIRECT),
        .EXT_DEPTH  (EXT_DEPTH),
        .EXT_DEVAD  (EXT_DEVAD)
    ) u_bank (
        .clk     (mdc),
        .rst_n   (rst_n),
        .acc_reg (acc_reg),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_done (rd_done),
        .rd_data (rd_data)
    );

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_tb;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = 5'd5;
    logic       mdio_in = 1'b1;
    logic       mdio_out, mdio_oe;
    int         n_chk = 0;
    int         n_fail = 0;

    localparam logic [4:0] ME = 5'd5;

    always #5 mdc = ~mdc;

    mdio_mgmt_slave u_dut (
        .mdc(mdc), .rst_n(rst_n), .phy_addr_strap(strap),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge mdc);
        mdio_in = b;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic header(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        repeat (pre) send_bit(1'b1);
        send_bits(16'b01, 2);
        send_bits({14'd0, op}, 2);
        send_bits({11'd0, phy}, 5);
        send_bits({11'd0, ra}, 5);
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] d,
                      input int pre = 32, input logic [1:0] op = 2'b01, input logic [4:0] phy = ME);
        header(pre, op, phy, ra);
        send_bits(16'b10, 2);
        send_bits(d, 16);
    endtask

    // matching read with turnaround checks (R5)
    task automatic rd(input logic [4:0] ra, output logic [15:0] d);
        logic lost = 1'b0;
        header(32, 2'b10, ME, ra);
        @(negedge mdc);
        chk("R5 ta1 oe", {15'd0, mdio_oe}, 16'd0);
        mdio_in = 1'b1;
        @(negedge mdc);
        chk("R5 ta2 oe/out", {14'd0, mdio_oe, mdio_out}, 16'd2);
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            d[i] = mdio_out;
            if (!mdio_oe) lost = 1'b1;
        end
        chk("R5 oe held in data", {15'd0, lost}, 16'd0);
        @(negedge mdc);
        chk("R5 oe released", {15'd0, mdio_oe}, 16'd0);
    endtask

    task automatic expect_reg(input string req, input logic [4:0] ra, input logic [15:0] exp);
        logic [15:0] d;
        rd(ra, d);
        chk(req, d, exp);
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge mdc);
        rst_n = 1'b0;
        strap = s;
        mdio_in = 1'b1;
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        chk("R6 reset oe", {15'd0, mdio_oe}, 16'd0);
        expect_reg("R6 reset reg0", 5'd0, 16'h0000);
        expect_reg("R7 reset ctrl", 5'h0D, 16'h0000);
    endtask

    task automatic t_direct;
        wr(5'd3, 16'hA5C3);
        expect_reg("R6 reg3 readback", 5'd3, 16'hA5C3);
        wr(5'd7, 16'h0F0F);
        expect_reg("R6 reg7 readback", 5'd7, 16'h0F0F);
        wr(5'h1F, 16'hFFFF);
        expect_reg("R6 unmapped reads 0", 5'h1F, 16'h0000);
        expect_reg("R6 reg3 kept", 5'd3, 16'hA5C3);
    endtask

    task automatic t_bad_opcode;
        wr(5'd2, 16'hBEEF, 32, 2'b11);
        expect_reg("R2 opcode 11 dropped", 5'd2, 16'h0000);
        wr(5'd2, 16'h1357, 32, 2'b00);
        expect_reg("R2 opcode 00 dropped", 5'd2, 16'h0000);
        wr(5'd2, 16'h1357, 40);
        expect_reg("R2 long preamble ok", 5'd2, 16'h1357);
    endtask

    task automatic t_short_pre;
        send_bit(1'b0);
        wr(5'd4, 16'h4444, 31);
        expect_reg("R3 31 ones ignored", 5'd4, 16'h0000);
    endtask

    task automatic t_foreign;
        logic seen = 1'b0;
        strap = 5'd6;
        wr(5'd0, 16'h5555, 32, 2'b01, 5'd6);
        expect_reg("R1 foreign write ignored", 5'd0, 16'h0000);
        header(32, 2'b10, 5'd6, 5'd3);
        repeat (20) begin
            @(negedge mdc);
            if (mdio_oe) seen = 1'b1;
        end
        chk("R1 no drive on foreign read", {15'd0, seen}, 16'd0);
        strap = ME;
    endtask

    task automatic t_ctrl;
        wr(5'h0D, 16'hFFFF);
        expect_reg("R7 ctrl field mask", 5'h0D, 16'hC01F);
    endtask

    task automatic t_fn_addr;
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'h0007);
        expect_reg("R8 pointer readback", 5'h0E, 16'h0007);
    endtask

    task automatic t_fn_data;
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'd7);
        wr(5'h0D, 16'h401F);
        wr(5'h0E, 16'h1234);
        expect_reg("R9 ext readback", 5'h0E, 16'h1234);
        expect_reg("R9 ext read again", 5'h0E, 16'h1234);
        wr(5'h0D, 16'h001F);
        expect_reg("R9 pointer unchanged", 5'h0E, 16'd7);
    endtask

    task automatic t_fn_inc_rw;
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'd10);
        wr(5'h0D, 16'h801F);
        wr(5'h0E, 16'h0A0A);
        wr(5'h0E, 16'h0B0B);
        wr(5'h0D, 16'h001F);
        expect_reg("R10 pointer after 2 writes", 5'h0E, 16'd12);
        wr(5'h0E, 16'd10);
        wr(5'h0D, 16'h801F);
        expect_reg("R10 read idx10", 5'h0E, 16'h0A0A);
        expect_reg("R10 read idx11", 5'h0E, 16'h0B0B);
        wr(5'h0D, 16'h001F);
        expect_reg("R10 pointer after 2 reads", 5'h0E, 16'd12);
    endtask

    task automatic t_fn_inc_wr;
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'd20);
        wr(5'h0D, 16'hC01F);
        wr(5'h0E, 16'h2020);
        wr(5'h0E, 16'h2121);
        wr(5'h0D, 16'h001F);
        expect_reg("R11 pointer after writes", 5'h0E, 16'd22);
        wr(5'h0E, 16'd20);
        wr(5'h0D, 16'hC01F);
        expect_reg("R11 read idx20", 5'h0E, 16'h2020);
        expect_reg("R11 read no step", 5'h0E, 16'h2020);
        wr(5'h0D, 16'h401F);
        wr(5'h0E, 16'd0);
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'd21);
        wr(5'h0D, 16'h401F);
        expect_reg("R11 idx21", 5'h0E, 16'h2121);
    endtask

    task automatic t_other_dev;
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'd9);
        wr(5'h0D, 16'h401F);
        wr(5'h0E, 16'h9999);
        wr(5'h0D, 16'h4003);
        wr(5'h0E, 16'h7777);
        expect_reg("R12 other device reads 0", 5'h0E, 16'h0000);
        wr(5'h0D, 16'h8003);
        wr(5'h0E, 16'h6666);
        wr(5'h0D, 16'h001F);
        expect_reg("R12 pointer unchanged", 5'h0E, 16'd9);
        wr(5'h0D, 16'h401F);
        expect_reg("R12 ext kept", 5'h0E, 16'h9999);
        wr(5'h0D, 16'h001F);
        wr(5'h0E, 16'd40);
        wr(5'h0D, 16'h401F);
        wr(5'h0E, 16'hAAAA);
        expect_reg("R12 out of range reads 0", 5'h0E, 16'h0000);
    endtask

    task automatic t_quiet;
        do_reset(ME);
        wr(5'd1, 16'h1111, 31);
        expect_reg("R4 first sample discarded", 5'd1, 16'h0000);
        do_reset(ME);
        wr(5'd1, 16'h2222, 32);
        expect_reg("R4 extra one accepted", 5'd1, 16'h2222);
    endtask

    initial begin
        repeat (150000) @(posedge mdc);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(ME);
        t_reset_state();
        t_direct();
        t_bad_opcode();
        t_short_pre();
        t_foreign();
        t_ctrl();
        t_fn_addr();
        t_fn_data();
        t_fn_inc_rw();
        t_fn_inc_wr();
        t_other_dev();
        t_quiet();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule